// File: doc/BRIEF.md
# Upset-Guarded Counter Register

This block holds a small piece of state (an up-counter that can also be loaded) in redundant copies so that a single-event upset in one flop does not corrupt the value seen by the rest of the chip. It can be built in one of two ways, selected by a parameter when the design is elaborated.

In triple mode there are three copies of the register. A bitwise two-of-three majority vote produces the output. The same voted value also feeds the next-state logic of all three copies. A copy that was hit is therefore overwritten with the majority value at the next clock edge, and errors cannot build up over time. Any disagreement between a copy and the vote sets a sticky flag, which can be cleared with an input. In duplicate mode there are two copies that are only compared. The output comes from the first copy and nothing is corrected. A difference raises a sticky mismatch flag that stays set until the block is reset, because in this mode recovery is a reset requested by logic outside the block.

Test inputs can flip one chosen bit of one chosen copy at one clock edge. This lets a bench or a built-in self-test show that an upset is masked and then repaired.

Top module: `upset_guard_reg`

## Requirements
- R1: While reset is asserted, every copy holds RST_VAL, the output equals RST_VAL and both flags read 0. The reset takes effect without a clock and is released in step with the clock.
- R2: When en=1 and ld=1 at a clock edge, the output equals din after that edge.
- R3: When en=1 and ld=0 at a clock edge, the output becomes the previous output plus one, modulo 2^W, so all-ones wraps to zero.
- R4: When en=0 at a clock edge, the output keeps its value.
- R5: In triple mode the output is the bitwise majority of the three copies, so an upset in a single copy never changes the output.
- R6: In triple mode each copy is rewritten from the voted value at every edge. A copy flipped at one edge therefore agrees again after the next edge, and upsets in different copies at consecutive edges still leave the output correct.
- R7: In triple mode `disagree` becomes 1 at the edge after any copy differs from the vote. It then holds until a clock edge with clr_disagree=1 at which no copy differs. A new disagreement wins over a clear at the same edge.
- R8: In duplicate mode the output is copy 0 and nothing is repaired. An upset in copy 1 leaves the output unchanged. An upset in copy 0 changes the output, and the counter carries on from the corrupted value.
- R9: In duplicate mode `mismatch` is 1 as soon as the two copies differ and stays 1 until reset, even after the copies agree again. `mismatch` is always 0 in triple mode, and `disagree` is always 0 in duplicate mode.
- R10: When inj_en=1, the bit given by inj_bit of the copy given by inj_sel (0, 1 or 2) is inverted as it is stored at that edge. A value of inj_sel that names no existing copy (3, or 2 in duplicate mode) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Update enable; when 0 the value is held |
| ld | input | 1 | With en=1: 1 loads din, 0 increments |
| din | input | W | Value to load |
| inj_en | input | 1 | Upset injection strobe (test) |
| inj_sel | input | 2 | Copy to corrupt (test) |
| inj_bit | input | BW | Bit to invert (test) |
| clr_disagree | input | 1 | Clears the sticky disagreement flag |
| q | output | W | Protected value (voted in triple mode, copy 0 in duplicate mode) |
| disagree | output | 1 | Sticky: a copy differed from the vote (triple mode) |
| mismatch | output | 1 | Sticky until reset: the two copies differed (duplicate mode) |

## Verification
Some properties are checked by assertions on every cycle. These are load, increment and hold at the output; that at most one copy ever differs from the vote; that all copies agree whenever the previous edge carried no injection; and that both flags are sticky.

Other behaviour can only be shown by the bench's scenarios, because it depends on particular sequences of stimulus. These are the exact edge at which `disagree` rises, a clear losing to a simultaneous disagreement, an out-of-range select being ignored, and a corrupted copy 0 carrying its error forward in duplicate mode. Both modes are driven by the same random stream mixed with directed upsets.

// File: rtl/ug_pkg.sv
package ug_pkg;
  typedef enum logic {UG_TRIPLE = 1'b0, UG_DUAL = 1'b1} ug_mode_e;

  function automatic int ug_copies(ug_mode_e m);
    return (m == UG_TRIPLE) ? 3 : 2;
  endfunction
endpackage

// File: rtl/ug_rst_sync.sv
module ug_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign srst_n = stage[1];
endmodule

// File: rtl/ug_replica.sv
module ug_replica #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] flip,
  output logic [W-1:0] q
);
  logic [W-1:0] d_n;

  always_comb d_n = d ^ flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d_n;
  end
endmodule

// File: rtl/ug_vote3.sv
module ug_vote3 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  always_comb y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/ug_next.sv
module ug_next #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (en && ld)  nxt = din;
    else if (en)   nxt = cur + W'(1);
    else           nxt = cur;
  end
endmodule

// File: rtl/upset_guard_reg.sv
module upset_guard_reg
  import ug_pkg::*;
#(
  parameter int W = 8,
  parameter ug_mode_e MODE = UG_TRIPLE,
  parameter logic [W-1:0] RST_VAL = '0,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ld,
  input  logic [W-1:0]  din,
  input  logic          inj_en,
  input  logic [1:0]    inj_sel,
  input  logic [BW-1:0] inj_bit,
  input  logic          clr_disagree,
  output logic [W-1:0]  q,
  output logic          disagree,
  output logic          mismatch
);
  localparam int NC = ug_copies(MODE);

  logic         rst_s;
  logic [W-1:0] rep_d [NC];
  logic [W-1:0] rep_q [NC];
  logic [W-1:0] flip  [NC];

  ug_rst_sync u_rsync (.clk(clk), .arst_n(rst_n), .srst_n(rst_s));

  // one register per copy, each with its own upset hook
  for (genvar i = 0; i < NC; i++) begin : g_rep
    assign flip[i] = (inj_en && (inj_sel == 2'(i))) ? (W'(1) << inj_bit) : '0;
    ug_replica #(.W(W), .RST_VAL(RST_VAL)) u_rep (
      .clk(clk), .rst_n(rst_s), .d(rep_d[i]), .flip(flip[i]), .q(rep_q[i])
    );
  end

  if (MODE == UG_TRIPLE) begin : g_tmr
    logic [W-1:0] voted;
    logic [W-1:0] nxt;
    logic         any_diff;
    logic         dis_q, dis_n;

    ug_vote3 #(.W(W)) u_vote (.a(rep_q[0]), .b(rep_q[1]), .c(rep_q[2]), .y(voted));

    // vote sits inside the loop: every copy is rebuilt from the voted value
    ug_next #(.W(W)) u_nxt (.cur(voted), .en(en), .ld(ld), .din(din), .nxt(nxt));
    for (genvar i = 0; i < NC; i++) begin : g_fb
      assign rep_d[i] = nxt;
    end

    assign any_diff = (rep_q[0] != voted) | (rep_q[1] != voted) | (rep_q[2] != voted);

    always_comb dis_n = any_diff | (dis_q & ~clr_disagree);

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) dis_q <= 1'b0;
      else        dis_q <= dis_n;
    end

    assign q        = voted;
    assign disagree = dis_q;
    assign mismatch = 1'b0;

    // R2: a load shows at the output after one edge
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_s)
      en && ld |=> q == $past(din));
    // R3: increment with wrap
    p_count_r3: assert property (@(posedge clk) disable iff (!rst_s)
      en && !ld |=> q == ($past(q) + W'(1)));
    // R4, R5: hold is kept even while one copy is being hit
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_s)
      !en |=> $stable(q));
    // R5, R6: repair keeps the damage to one copy at a time
    p_one_bad_copy_r5: assert property (@(posedge clk) disable iff (!rst_s)
      $countones({rep_q[0] != voted, rep_q[1] != voted, rep_q[2] != voted}) <= 1);
    // R6: without an injection at the last edge all copies agree
    p_repaired_r6: assert property (@(posedge clk) disable iff (!rst_s)
      !$past(inj_en && (inj_sel != 2'd3)) |-> (rep_q[0] == rep_q[1]) && (rep_q[1] == rep_q[2]));
    // R7: disagreement is recorded one edge later and is sticky
    p_dis_set_r7: assert property (@(posedge clk) disable iff (!rst_s)
      any_diff |=> disagree);
    p_dis_sticky_r7: assert property (@(posedge clk) disable iff (!rst_s)
      disagree && !clr_disagree |=> disagree);
  end else begin : g_dmr
    logic mis_q, mis_n;
    logic live_diff;

    // each copy follows only itself: detection, no correction
    for (genvar i = 0; i < NC; i++) begin : g_own
      ug_next #(.W(W)) u_nxt (.cur(rep_q[i]), .en(en), .ld(ld), .din(din), .nxt(rep_d[i]));
    end

    assign live_diff = (rep_q[0] != rep_q[1]);

    always_comb mis_n = mis_q | live_diff;

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) mis_q <= 1'b0;
      else        mis_q <= mis_n;
    end

    assign q        = rep_q[0];
    assign disagree = 1'b0;
    assign mismatch = mis_q | live_diff;

    // R9: mismatch persists until reset
    p_mis_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s)
      mismatch |=> mismatch);
    // R8: with no update and no upset, copy 0 is left alone
    p_dual_hold_r8: assert property (@(posedge clk) disable iff (!rst_s)
      !en && !inj_en |=> $stable(q));
    // R2: load reaches the output when copy 0 is not being hit
    p_dual_load_r2: assert property (@(posedge clk) disable iff (!rst_s)
      en && ld && !(inj_en && inj_sel == 2'd0) |=> q == $past(din));
  end
endmodule

// File: tb/upset_guard_reg_test.sv
module upset_guard_reg_test;
  import ug_pkg::*;

  localparam int W = 8;
  localparam logic [W-1:0] RV = 8'hA5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, en, ld, inj_en, clr;
  logic [W-1:0] din;
  logic [1:0]   sel;
  logic [2:0]   bsel;
  logic [W-1:0] t_q, d_q;
  logic         t_dis, t_mis, d_dis, d_mis;

  upset_guard_reg #(.W(W), .MODE(UG_TRIPLE), .RST_VAL(RV)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .din(din), .inj_en(inj_en),
    .inj_sel(sel), .inj_bit(bsel), .clr_disagree(clr),
    .q(t_q), .disagree(t_dis), .mismatch(t_mis));

  upset_guard_reg #(.W(W), .MODE(UG_DUAL), .RST_VAL(RV)) uut_dual (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .din(din), .inj_en(inj_en),
    .inj_sel(sel), .inj_bit(bsel), .clr_disagree(clr),
    .q(d_q), .disagree(d_dis), .mismatch(d_mis));

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // expected state, derived from the requirements
  logic [W-1:0] e_q, e_c0, e_c1;
  logic         e_dis, e_injp, e_mst;

  function automatic logic [W-1:0] f_next(logic [W-1:0] cur, logic e, logic l, logic [W-1:0] d);
    if (e && l) return d;
    if (e)      return cur + 8'd1;
    return cur;
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    e_q = RV; e_c0 = RV; e_c1 = RV;
    e_dis = 1'b0; e_injp = 1'b0; e_mst = 1'b0;
  endtask

  task automatic check_all(string tag);
    chk(tag,  "tmr q",         t_q, e_q);
    chk("R7", "tmr disagree",  W'(t_dis), W'(e_dis));
    chk("R8", "dual q",        d_q, e_c0);
    chk("R9", "dual mismatch", W'(d_mis), W'(e_mst | (e_c0 != e_c1)));
    chk("R9", "tmr mismatch",  W'(t_mis), '0);
    chk("R9", "dual disagree", W'(d_dis), '0);
  endtask

  // drive at the falling edge, model the rising edge, check at the next falling edge
  task automatic cyc(logic e, logic l, logic [W-1:0] d, logic ie, logic [1:0] s,
                     logic [2:0] b, logic c, string tag);
    logic [W-1:0] m;
    en = e; ld = l; din = d; inj_en = ie; sel = s; bsel = b; clr = c;
    @(posedge clk);
    m = W'(1) << b;
    e_mst = e_mst | (e_c0 != e_c1);
    e_c0  = f_next(e_c0, e, l, d) ^ ((ie && s == 2'd0) ? m : '0);
    e_c1  = f_next(e_c1, e, l, d) ^ ((ie && s == 2'd1) ? m : '0);
    e_dis = e_injp | (e_dis & ~c);
    e_injp = ie && (s != 2'd3);
    e_q   = f_next(e_q, e, l, d);
    @(negedge clk);
    inj_en = 1'b0; clr = 1'b0;
    check_all(tag);
  endtask

  initial begin
    rst_n = 1'b0; en = 0; ld = 0; din = '0; inj_en = 0; sel = '0; bsel = '0; clr = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // load, count, wrap
    cyc(1, 1, 8'hFE, 0, 0, 0, 0, "R2");
    cyc(1, 0, 8'h00, 0, 0, 0, 0, "R3");
    cyc(1, 0, 8'h00, 0, 0, 0, 0, "R3");   // FF -> 00
    cyc(0, 0, 8'h77, 0, 0, 0, 0, "R4");
    // single upsets walked over all three copies on consecutive edges
    cyc(0, 0, 8'h00, 1, 0, 3, 0, "R5");
    cyc(0, 0, 8'h00, 1, 1, 3, 0, "R6");
    cyc(0, 0, 8'h00, 1, 2, 3, 0, "R6");
    cyc(1, 0, 8'h00, 0, 0, 0, 0, "R6");
    // clear with nothing new pending drops the flag
    cyc(0, 0, 8'h00, 0, 0, 0, 1, "R7");
    // clear coinciding with a fresh disagreement loses
    cyc(0, 0, 8'h00, 1, 0, 7, 0, "R7");
    cyc(0, 0, 8'h00, 0, 0, 0, 1, "R7");
    cyc(0, 0, 8'h00, 0, 0, 0, 1, "R7");
    // select naming no copy is ignored
    cyc(0, 0, 8'h00, 1, 3, 0, 0, "R10");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, "R10");
    // duplicate mode: corrupted copy 0 carries its error forward
    cyc(1, 1, 8'h10, 0, 0, 0, 0, "R2");
    cyc(0, 0, 8'h00, 1, 0, 0, 0, "R8");
    cyc(1, 0, 8'h00, 0, 0, 0, 0, "R8");
    // copies reconverge on a load, mismatch stays up
    cyc(1, 1, 8'h33, 0, 0, 0, 0, "R9");
    cyc(0, 0, 8'h00, 1, 1, 5, 0, "R10");

    // random mix with a fixed seed
    void'($urandom(32'd20511));
    for (int k = 0; k < 3000; k++) begin
      logic re, rl, ri, rc;
      logic [W-1:0] rd;
      logic [1:0] rs;
      logic [2:0] rb;
      string tg;
      re = ($urandom % 4) != 0;
      rl = ($urandom % 5) == 0;
      ri = ($urandom % 4) == 0;
      rc = ($urandom % 8) == 0;
      rd = W'($urandom);
      rs = 2'($urandom);
      rb = 3'($urandom);
      tg = ri ? "R5" : (!re ? "R4" : (rl ? "R2" : "R3"));
      cyc(re, rl, rd, ri, rs, rb, rc, tg);
    end

    // asynchronous reset in mid-run clears the sticky mismatch
    rst_n = 1'b0;
    #1;
    model_reset();
    check_all("R1");
    chk("R9", "dual mismatch after reset", W'(d_mis), '0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule